// File: doc/BRIEF.md
# Four-Way Set Replacement Victim Selector

This block keeps the replacement state of a single four-way cache set and reports, every cycle, which way a controller should overwrite on the next fill. One state store serves three policies: exact least-recently-used ordering, first-in-first-out ordering, and a pseudo-random choice. A two-bit select picks the policy. The select is sampled once, on the first rising clock after reset is released.

The surrounding cache controller reports each lookup on the access strobe. It raises the hit flag on a hit and puts the way on the way input. When it writes a new line into the set it raises the fill strobe with the target way. The victim output is combinational from registered state, so the choice is ready in the same cycle it is asked for. Any update becomes visible on the next cycle, and there is never a stall. While some way is still invalid, the victim is always the lowest-numbered invalid way, whatever the policy.

Top module: `set_victim_sel`

## Requirements
- R1: Policy encoding on policy_i is 00 LRU, 01 FIFO, 10 random and 11 LRU. The value is captured on the first rising clock after rst_ni goes high, and later changes of policy_i have no effect until the next reset.
- R2: After reset every way is invalid, full_o is 0 and victim_o is 0. The LRU age of way i is i, the FIFO pointer is 0 and the random generator holds 16'hACE1.
- R3: A fill marks way acc_way_i valid. full_o is 1 exactly when all four ways are valid. While full_o is 0, victim_o is the lowest-numbered invalid way.
- R4: In LRU mode a touch (acc_valid_i with hit_i, or fill_i) on way w clears the age of w to 0. Every way whose age was below the old age of w increments by one, and other ages are unchanged.
- R5: In LRU mode with the set full, victim_o is the way whose age is 3, which is the least recently touched way.
- R6: acc_valid_i without hit_i and without fill_i changes no state.
- R7: In FIFO mode each fill advances the pointer by one modulo 4. With the set full, victim_o equals the pointer.
- R8: In FIFO mode a hit leaves the pointer, and so victim_o, unchanged.
- R9: In random mode a 16-bit register shifts left every clock after reset, with new bit 0 = b15^b13^b12^b10. With the set full, victim_o equals its two low bits, and hits have no influence on it.
- R10: victim_o reflects the current registered state in the same cycle. An update shows on the cycle after its strobe, with no wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | Replacement policy select, sampled after reset |
| acc_valid_i | input | 1 | A lookup to this set occurs this cycle |
| hit_i | input | 1 | The lookup hit on acc_way_i |
| fill_i | input | 1 | A line is written into acc_way_i this cycle |
| acc_way_i | input | 2 | Way that was hit or filled |
| victim_o | output | 2 | Way to replace on the next fill |
| full_o | output | 1 | All four ways hold valid lines |

## Verification
The LRU sequence includes a hit on the current oldest way, a repeated hit on the most recent way, a bare miss and a fill over a valid way. A design that aged every way unconditionally, or that counted a miss as a touch, would name the wrong victim. In FIFO mode, hits between fills catch a pointer that moves on hits, which would make FIFO behave like LRU. In random mode the victim is compared each cycle against a generator model while hits are applied, so a stuck generator, a wrong tap set or one gated by accesses shows up. Changing the select after reset, and the 11 code, catch a design that follows the live select pin.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  typedef enum logic [1:0] {
    POL_LRU  = 2'd0,
    POL_FIFO = 2'd1,
    POL_RAND = 2'd2,
    POL_LRU2 = 2'd3
  } pol_e;

  localparam logic [15:0] RND_SEED = 16'hACE1;
endpackage

// File: rtl/vsel_lru_ages.sv
module vsel_lru_ages #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] way_i,
  output logic [WAY_W-1:0] victim_o
);
  logic [WAY_W-1:0] age_q [NUM_WAYS];
  logic [NUM_WAYS-1:0] oldest;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_WAYS; i++) age_q[i] <= WAY_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < NUM_WAYS; i++) begin
        if (WAY_W'(i) == way_i)          age_q[i] <= '0;
        else if (age_q[i] < age_q[way_i]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_old
    assign oldest[g] = (age_q[g] == WAY_W'(NUM_WAYS - 1));
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < NUM_WAYS; i++)
      if (oldest[i]) victim_o = WAY_W'(i);
  end

  // R5
  lru_one_oldest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(oldest) == 1);
  // R4
  lru_touch_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> age_q[$past(way_i)] == '0);
endmodule

// File: rtl/vsel_fifo_ptr.sv
module vsel_fifo_ptr #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [WAY_W-1:0] ptr_o
);
  logic [WAY_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == WAY_W'(NUM_WAYS - 1)) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/vsel_lfsr.sv
module vsel_lfsr #(
  parameter int NUM_WAYS = 4,
  parameter logic [15:0] SEED = 16'hACE1,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [WAY_W-1:0] rnd_o
);
  logic [15:0] st_q;
  logic        fb;

  assign fb = st_q[15] ^ st_q[13] ^ st_q[12] ^ st_q[10];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SEED;
    else         st_q <= {st_q[14:0], fb};
  end

  assign rnd_o = st_q[WAY_W-1:0];

  // R9
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != '0);
endmodule

// File: rtl/set_victim_sel.sv
module set_victim_sel #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       policy_i,
  input  logic             acc_valid_i,
  input  logic             hit_i,
  input  logic             fill_i,
  input  logic [WAY_W-1:0] acc_way_i,
  output logic [WAY_W-1:0] victim_o,
  output logic             full_o
);
  import vsel_pkg::*;

  pol_e                pol_q;
  logic                armed_q;
  logic [NUM_WAYS-1:0] valid_q;
  logic                is_lru, is_fifo;
  logic                touch;
  logic [WAY_W-1:0]    lru_victim, fifo_ptr, rnd_way, free_way;

  // policy is latched once after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q   <= POL_LRU;
      armed_q <= 1'b0;
    end else if (!armed_q) begin
      pol_q   <= pol_e'(policy_i);
      armed_q <= 1'b1;
    end
  end

  assign is_lru  = (pol_q == POL_LRU) || (pol_q == POL_LRU2);
  assign is_fifo = (pol_q == POL_FIFO);
  assign touch   = is_lru && ((acc_valid_i && hit_i) || fill_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     valid_q <= '0;
    else if (fill_i) valid_q[acc_way_i] <= 1'b1;
  end

  assign full_o = &valid_q;

  always_comb begin
    free_way = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--)
      if (!valid_q[i]) free_way = WAY_W'(i);
  end

  vsel_lru_ages #(.NUM_WAYS(NUM_WAYS)) u_lru (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .touch_i  (touch),
    .way_i    (acc_way_i),
    .victim_o (lru_victim)
  );

  vsel_fifo_ptr #(.NUM_WAYS(NUM_WAYS)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (fill_i && is_fifo),
    .ptr_o  (fifo_ptr)
  );

  vsel_lfsr #(.NUM_WAYS(NUM_WAYS), .SEED(RND_SEED)) u_rnd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rnd_o  (rnd_way)
  );

  always_comb begin
    if (!full_o)                victim_o = free_way;
    else if (pol_q == POL_FIFO) victim_o = fifo_ptr;
    else if (pol_q == POL_RAND) victim_o = rnd_way;
    else                        victim_o = lru_victim;
  end

  // R3
  free_victim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_o |-> !valid_q[victim_o]);
  // R3
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(full_o));
  // R1
  pol_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> $stable(pol_q));
  // R8
  fifo_hit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !fill_i) |=> $stable(fifo_ptr));
  // R7
  fifo_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && is_fifo) |=> fifo_ptr == $past(fifo_ptr) + 1'b1);
endmodule

// File: tb/sim_set_victim_sel.sv
`timescale 1ns/1ps
module sim_set_victim_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] policy = 2'b00;
  logic       acc_valid = 1'b0, hit = 1'b0, fill = 1'b0;
  logic [1:0] way = 2'b00;
  logic [1:0] victim;
  logic       full;
  int         total = 0, bad = 0;
  logic [15:0] rmod;
  logic [3:0]  seen;

  always #10 clk = ~clk;

  set_victim_sel u0 (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(policy),
    .acc_valid_i(acc_valid), .hit_i(hit), .fill_i(fill),
    .acc_way_i(way), .victim_o(victim), .full_o(full)
  );

  // generator model per R9
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rmod <= 16'hACE1;
    else        rmod <= {rmod[14:0], rmod[15] ^ rmod[13] ^ rmod[12] ^ rmod[10]};
  end

  // bits: [7] acc_valid [6] hit [5] fill [4:3] way [2:1] exp victim [0] exp full
  localparam int NV = 11;
  localparam logic [7:0] LRU_TBL [NV] = '{
    8'b001_00_01_0, 8'b001_01_10_0, 8'b001_10_11_0, 8'b001_11_00_1,
    8'b110_00_01_1, 8'b110_10_01_1, 8'b100_00_01_1, 8'b001_01_11_1,
    8'b110_11_00_1, 8'b110_00_10_1, 8'b110_00_10_1
  };

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] pol);
    @(negedge clk);
    policy = pol; rst_n = 1'b0; acc_valid = 0; hit = 0; fill = 0; way = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic op(input logic v, input logic h, input logic f, input logic [1:0] w);
    acc_valid = v; hit = h; fill = f; way = w;
    @(negedge clk);
    acc_valid = 0; hit = 0; fill = 0;
    #1;
  endtask

  task automatic fill_all();
    for (int i = 0; i < 4; i++) op(1'b0, 1'b0, 1'b1, 2'(i));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R2 reset state, R1 LRU selected
    do_reset(2'b00);
    #1;
    chk("R2 victim after reset", victim, 0);
    chk("R2 full after reset", full, 0);

    // R3 R4 R5 R6 R10 LRU table
    for (int k = 0; k < NV; k++) begin
      op(LRU_TBL[k][7], LRU_TBL[k][6], LRU_TBL[k][5], LRU_TBL[k][4:3]);
      chk($sformatf("R4/R5 lru step %0d victim", k), victim, LRU_TBL[k][2:1]);
      chk($sformatf("R3 lru step %0d full", k), full, LRU_TBL[k][0]);
    end

    // R7 R8 FIFO
    do_reset(2'b01);
    op(1'b0, 1'b0, 1'b1, 2'd0);
    chk("R3 fifo first free", victim, 1);
    op(1'b0, 1'b0, 1'b1, 2'd1);
    op(1'b0, 1'b0, 1'b1, 2'd2);
    op(1'b0, 1'b0, 1'b1, 2'd3);
    chk("R7 fifo full victim", victim, 0);
    chk("R3 fifo full", full, 1);
    op(1'b1, 1'b1, 1'b0, 2'd0);
    chk("R8 fifo hit oldest", victim, 0);
    op(1'b1, 1'b1, 1'b0, 2'd3);
    op(1'b1, 1'b1, 1'b0, 2'd1);
    chk("R8 fifo hits ignored", victim, 0);
    op(1'b0, 1'b0, 1'b1, 2'd0);
    chk("R7 fifo advance", victim, 1);
    op(1'b1, 1'b1, 1'b0, 2'd1);
    chk("R8 fifo hit pointer way", victim, 1);
    op(1'b0, 1'b0, 1'b1, 2'd1);
    chk("R7 fifo advance again", victim, 2);
    op(1'b1, 1'b0, 1'b0, 2'd2);
    chk("R6 fifo miss no change", victim, 2);

    // R9 random
    do_reset(2'b10);
    #1;
    chk("R2 rand reset victim", victim, 0);
    fill_all();
    chk("R3 rand full", full, 1);
    seen = '0;
    for (int k = 0; k < 40; k++) begin
      op(1'b1, 1'b1, 1'b0, 2'(k));
      chk("R9 rand victim", victim, rmod[1:0]);
      seen[victim] = 1'b1;
    end
    chk("R9 rand covers all ways", seen, 4'hF);

    // R1 select change after reset ignored
    do_reset(2'b00);
    policy = 2'b01;
    fill_all();
    op(1'b1, 1'b1, 1'b0, 2'd0);
    chk("R1 late select ignored", victim, 1);

    // R1 code 11 acts as LRU
    do_reset(2'b11);
    fill_all();
    chk("R5 code11 oldest", victim, 0);
    op(1'b1, 1'b1, 1'b0, 2'd0);
    chk("R1 code11 lru", victim, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule